// File: doc/BRIEF.md
# Power-up configuration loader for a panel timing controller

After reset, this block reads the configuration bytes of a panel timing controller from an external serial EEPROM. It builds them into four registers:

- a 16-bit output-format word
- an 8-bit input-format word
- an 11-bit horizontal back porch
- an 11-bit vertical back porch

It talks to an EEPROM master through a byte-read port. The loader raises a request with an address and holds it. The master answers later with a one-cycle valid strobe that carries the data byte.

The first read is a presence probe. The EEPROM counts as present only if the probe returns 00H. Any other value means no EEPROM is fitted. In that case the loader makes no further reads and applies one of two built-in default sets, chosen by a select pin. The done flag goes high once the registers hold their final values. Downstream timing logic stays idle until done is high. The load runs once per reset.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted, `done` and `rd_req` are low and all four configuration outputs are zero.
- R2: The first request after reset reads the probe address (parameter `PROBE_ADDR`, default 80H).
- R3: If the probe returns 00H, the loader then reads 81H, 82H, 85H, 86H, 87H, 88H and 89H, in that order. `rd_req` falls for at least one cycle between two requests.
- R4: If the probe returns any value other than 00H, no further request is made. If `dflt_sel` is 0 when the probe answer is taken, the outputs become out 0018H, in 10H, hbp 296, vbp 35. If `dflt_sel` is 1, they become out 1208H, in 18H, hbp 160, vbp 29.
- R5: With an EEPROM present, `out_fmt` equals {byte at 82H, byte at 81H}.
- R6: With an EEPROM present, `in_fmt` equals the byte at 85H.
- R7: `hbp` equals {bits 2:0 of the byte at 87H, byte at 86H}, and `vbp` equals {bits 2:0 of the byte at 89H, byte at 88H}. Bits 7:3 of the bytes at 87H and 89H have no effect.
- R8: `done` rises in the cycle after the final response is taken, whether that response is the last EEPROM byte or a nonzero probe. It then stays high, no further request is raised, and the outputs hold their values until reset.
- R9: A `rd_valid` pulse while `rd_req` is low, including after `done`, has no effect.
- R10: While a request waits for its answer, `rd_req` stays high and `rd_addr` holds steady, however many cycles that takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dflt_sel | input | 1 | Selects default set 0 or 1 when no EEPROM is found |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | 8 | EEPROM byte address of the pending request |
| rd_valid | input | 1 | One-cycle strobe: `rd_data` answers the pending request |
| rd_data | input | 8 | Byte returned by the EEPROM master |
| done | output | 1 | Configuration registers final |
| out_fmt | output | 16 | Output-format control word |
| in_fmt | output | 8 | Input-format control word |
| hbp | output | 11 | Horizontal back porch |
| vbp | output | 11 | Vertical back porch |

## Verification
The assertions assume that the master answers each request with exactly one `rd_valid` pulse, one cycle long. Stray pulses while `rd_req` is low are allowed, since R9 covers them. The bench drives its responder on the falling edge. It answers only after it has seen `rd_req` high, waits a varied latency first, and drops `rd_valid` after one cycle. It injects stray pulses only in cycles where the request line is low, both between reads and after `done`.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int OUT_W   = 16;
  localparam int IN_W    = 8;
  localparam int PORCH_W = 11;
  localparam int N_STEPS = 8;                  // probe + seven data bytes
  localparam int IDX_W   = $clog2(N_STEPS);
  localparam int HI_W    = PORCH_W - BYTE_W;   // porch bits held in the high byte

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic [OUT_W-1:0]   out_fmt;
    logic [IN_W-1:0]    in_fmt;
    logic [PORCH_W-1:0] hbp;
    logic [PORCH_W-1:0] vbp;
  } cfg_t;

  typedef enum logic [1:0] {ST_GAP, ST_REQ, ST_DONE} ld_state_t;

  localparam idx_t LAST_IDX = idx_t'(N_STEPS - 1);

  // EEPROM address fetched at each data step (step 0 is the probe)
  function automatic logic [ADDR_W-1:0] step_addr(idx_t idx);
    case (idx)
      idx_t'(1): step_addr = 8'h81;
      idx_t'(2): step_addr = 8'h82;
      idx_t'(3): step_addr = 8'h85;
      idx_t'(4): step_addr = 8'h86;
      idx_t'(5): step_addr = 8'h87;
      idx_t'(6): step_addr = 8'h88;
      idx_t'(7): step_addr = 8'h89;
      default:   step_addr = 8'h80;
    endcase
  endfunction

  // Place one fetched byte into the configuration image
  function automatic cfg_t cfg_merge(cfg_t cur, idx_t idx, logic [BYTE_W-1:0] b);
    cfg_t nxt;
    nxt = cur;
    case (idx)
      idx_t'(1): nxt.out_fmt[BYTE_W-1:0]        = b;
      idx_t'(2): nxt.out_fmt[OUT_W-1:BYTE_W]    = b;
      idx_t'(3): nxt.in_fmt                     = b;
      idx_t'(4): nxt.hbp[BYTE_W-1:0]            = b;
      idx_t'(5): nxt.hbp[PORCH_W-1:BYTE_W]      = b[HI_W-1:0];
      idx_t'(6): nxt.vbp[BYTE_W-1:0]            = b;
      idx_t'(7): nxt.vbp[PORCH_W-1:BYTE_W]      = b[HI_W-1:0];
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PROBE_ADDR = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output idx_t              wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              dflt_load,
  output logic              done
);

  ld_state_t st;
  idx_t      idx;

  // named internal events
  wire rsp_take   = (st == ST_REQ) && rd_valid;
  wire probe_step = (idx == '0);
  wire probe_hit  = rsp_take && probe_step && (rd_data == '0);
  wire probe_miss = rsp_take && probe_step && (rd_data != '0);
  wire last_take  = rsp_take && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_GAP;
      idx <= '0;
    end else begin
      case (st)
        ST_GAP: st <= ST_REQ;
        ST_REQ: begin
          if (probe_miss || last_take) begin
            st <= ST_DONE;
          end else if (probe_hit || rsp_take) begin
            st  <= ST_GAP;
            idx <= idx + idx_t'(1);
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  assign rd_req    = (st == ST_REQ);
  assign rd_addr   = probe_step ? PROBE_ADDR : step_addr(idx);
  assign wr_en     = rsp_take && !probe_step;
  assign wr_idx    = idx;
  assign wr_data   = rd_data;
  assign dflt_load = probe_miss;
  assign done      = (st == ST_DONE);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  // R3
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> !rd_req);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R8
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
  // R4
  miss_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probe_miss |=> done);

endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs
  import cfgld_pkg::*;
#(
  parameter cfg_t SET_A = '0,
  parameter cfg_t SET_B = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  idx_t              wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              dflt_load,
  input  logic              dflt_sel,
  output cfg_t              cfg
);

  cfg_t cfg_q;
  cfg_t dflt_pick;

  assign dflt_pick = dflt_sel ? SET_B : SET_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (dflt_load) begin
      cfg_q <= dflt_pick;
    end else if (wr_en) begin
      cfg_q <= cfg_merge(cfg_q, wr_idx, wr_data);
    end
  end

  assign cfg = cfg_q;

  // R4
  dflt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dflt_load |=> (cfg_q == ($past(dflt_sel) ? SET_B : SET_A)));
  // R7
  porch_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == idx_t'(5)) |=>
      (cfg_q.hbp[PORCH_W-1:BYTE_W] == $past(wr_data[HI_W-1:0])) &&
      $stable(cfg_q.hbp[BYTE_W-1:0]) && $stable(cfg_q.vbp));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgld_pkg::*;
#(
  parameter logic [ADDR_W-1:0]  PROBE_ADDR  = 8'h80,
  parameter logic [OUT_W-1:0]   DEFA_OUT    = 16'h0018,
  parameter logic [IN_W-1:0]    DEFA_IN     = 8'h10,
  parameter logic [PORCH_W-1:0] DEFA_HBP    = 11'd296,
  parameter logic [PORCH_W-1:0] DEFA_VBP    = 11'd35,
  parameter logic [OUT_W-1:0]   DEFB_OUT    = 16'h1208,
  parameter logic [IN_W-1:0]    DEFB_IN     = 8'h18,
  parameter logic [PORCH_W-1:0] DEFB_HBP    = 11'd160,
  parameter logic [PORCH_W-1:0] DEFB_VBP    = 11'd29
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dflt_sel,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_valid,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               done,
  output logic [OUT_W-1:0]   out_fmt,
  output logic [IN_W-1:0]    in_fmt,
  output logic [PORCH_W-1:0] hbp,
  output logic [PORCH_W-1:0] vbp
);

  localparam cfg_t SET_A = '{out_fmt: DEFA_OUT, in_fmt: DEFA_IN, hbp: DEFA_HBP, vbp: DEFA_VBP};
  localparam cfg_t SET_B = '{out_fmt: DEFB_OUT, in_fmt: DEFB_IN, hbp: DEFB_HBP, vbp: DEFB_VBP};

  logic              wr_en;
  idx_t              wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic              dflt_load;
  cfg_t              cfg;

  cfgld_seq #(.PROBE_ADDR(PROBE_ADDR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .dflt_load (dflt_load),
    .done      (done)
  );

  cfgld_regs #(.SET_A(SET_A), .SET_B(SET_B)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .dflt_load (dflt_load),
    .dflt_sel  (dflt_sel),
    .cfg       (cfg)
  );

  assign out_fmt = cfg.out_fmt;
  assign in_fmt  = cfg.in_fmt;
  assign hbp     = cfg.hbp;
  assign vbp     = cfg.vbp;

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(out_fmt) && $stable(in_fmt) && $stable(hbp) && $stable(vbp)));
  // R9
  stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_req) |=> ($stable(out_fmt) && $stable(in_fmt) && $stable(hbp) && $stable(vbp)));

endmodule

// File: tb/cfg_loader_test.sv
module cfg_loader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dflt_sel = 1'b0;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        rd_req;
  logic [7:0]  rd_addr;
  logic        done;
  logic [15:0] out_fmt;
  logic [7:0]  in_fmt;
  logic [10:0] hbp;
  logic [10:0] vbp;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  cfg_loader uut (
    .clk(clk), .rst_n(rst_n), .dflt_sel(dflt_sel),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .out_fmt(out_fmt), .in_fmt(in_fmt), .hbp(hbp), .vbp(vbp)
  );

  // byte image of the model EEPROM
  logic [7:0] probe_byte;
  int         seed;

  function automatic logic [7:0] eep(input logic [7:0] a, input int s);
    if (a == 8'h80) return probe_byte;
    if (s == 99) return 8'hFF;
    return 8'((int'(a) * 29 + s * 53)) ^ 8'hC8;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        finish_run();
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(done == 1'b0, "R1", "done in reset", 32'(done), 0);
    chk(rd_req == 1'b0, "R1", "rd_req in reset", 32'(rd_req), 0);
    chk({out_fmt, in_fmt, hbp, vbp} == '0, "R1", "outputs in reset",
        32'(out_fmt) ^ 32'(hbp), 0);
    rst_n = 1'b1;
  endtask

  // One complete load with the behavioural reference model
  task automatic run_load(input logic [7:0] pb, input bit sel, input int lat,
                          input bit stray, input int s);
    logic [7:0]  addrs[$];
    logic [15:0] e_out;
    logic [7:0]  e_in;
    logic [10:0] e_hbp, e_vbp;
    probe_byte = pb;
    seed = s;
    dflt_sel = sel;
    do_reset();
    addrs = {8'h80};
    if (pb == 8'h00) addrs = {8'h80, 8'h81, 8'h82, 8'h85, 8'h86, 8'h87, 8'h88, 8'h89};
    for (int k = 0; k < addrs.size(); k++) begin
      int w = 0;
      while (!rd_req && w < 50) begin
        @(negedge clk);
        w++;
      end
      // R2 / R3
      chk(rd_req && rd_addr == addrs[k], (k == 0) ? "R2" : "R3", "request address",
          32'(rd_addr), 32'(addrs[k]));
      for (int l = 0; l < lat + (k % 3); l++) begin
        @(negedge clk);
        // R10
        chk(rd_req && rd_addr == addrs[k], "R10", "held request", 32'(rd_addr), 32'(addrs[k]));
        chk(!done, "R8", "done early", 32'(done), 0);
      end
      // flip select mid-load: must not matter when an EEPROM is present
      if (pb == 8'h00 && k == 3) dflt_sel = ~sel;
      rd_valid = 1'b1;
      rd_data  = eep(addrs[k], s);
      @(negedge clk);
      rd_valid = 1'b0;
      rd_data  = 8'h00;
      // R3
      chk(!rd_req, "R3", "gap after response", 32'(rd_req), 0);
      // R8
      chk(done == (k == addrs.size() - 1), "R8", "done timing", 32'(done),
          32'(k == addrs.size() - 1));
      if (stray) begin
        // R9: stray strobe while request low
        rd_valid = 1'b1;
        rd_data  = 8'hFF;
        @(negedge clk);
        rd_valid = 1'b0;
        rd_data  = 8'h00;
      end
    end
    if (pb == 8'h00) begin
      e_out = {eep(8'h82, s), eep(8'h81, s)};
      e_in  = eep(8'h85, s);
      e_hbp = {eep(8'h87, s)[2:0], eep(8'h86, s)};
      e_vbp = {eep(8'h89, s)[2:0], eep(8'h88, s)};
    end else if (!sel) begin
      e_out = 16'h0018; e_in = 8'h10; e_hbp = 11'd296; e_vbp = 11'd35;
    end else begin
      e_out = 16'h1208; e_in = 8'h18; e_hbp = 11'd160; e_vbp = 11'd29;
    end
    // R4 / R5 / R6 / R7
    chk(out_fmt == e_out, (pb == 0) ? "R5" : "R4", "out_fmt", 32'(out_fmt), 32'(e_out));
    chk(in_fmt == e_in, (pb == 0) ? "R6" : "R4", "in_fmt", 32'(in_fmt), 32'(e_in));
    chk(hbp == e_hbp, (pb == 0) ? "R7" : "R4", "hbp", 32'(hbp), 32'(e_hbp));
    chk(vbp == e_vbp, (pb == 0) ? "R7" : "R4", "vbp", 32'(vbp), 32'(e_vbp));
    // post-done: stray strobes, no requests, outputs frozen (R8, R9)
    for (int i = 0; i < 6; i++) begin
      rd_valid = (i % 2 == 0);
      rd_data  = 8'h00;
      dflt_sel = ~dflt_sel;
      @(negedge clk);
      chk(done && !rd_req, "R8", "stays done, no request", 32'({done, rd_req}), 32'b10);
      chk(out_fmt == e_out && in_fmt == e_in && hbp == e_hbp && vbp == e_vbp,
          "R9", "outputs unchanged after done", 32'(out_fmt), 32'(e_out));
    end
    rd_valid = 1'b0;
  endtask

  initial begin
    run_load(8'h00, 1'b0, 0, 1'b1, 1);
    run_load(8'h00, 1'b1, 3, 1'b0, 2);
    run_load(8'h00, 1'b0, 1, 1'b1, 99);   // high porch bits all set
    run_load(8'h5A, 1'b0, 2, 1'b0, 3);
    run_load(8'hFF, 1'b1, 0, 1'b1, 4);
    run_load(8'h01, 1'b0, 5, 1'b1, 5);
    run_load(8'h80, 1'b1, 7, 1'b0, 6);
    run_load(8'h00, 1'b1, 9, 1'b1, 7);
    finish_run();
  end

endmodule